// File: doc/BRIEF.md
# Interrupt Line Aggregator

This block gathers a parameterised set of interrupt request lines, up to the 32-bit data width, into one interrupt output. Each line can be blocked before capture, set to capture rising edges or high levels, and held in a sticky pending bit. Software clears a pending bit by writing one to it. A separate per-line enable decides whether a pending bit can reach the output. A global mode setting drives the output either as a level or as a single-cycle pulse.

Software reaches the block through a plain register port. A write takes effect at the next clock edge, and a read returns data in the same cycle from the selected register. The block carries no data stream, so it has no valid/ready pins and exerts no back-pressure. All request lines are assumed to be synchronous to `clk`.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: With register select codes 0 = gate, 1 = trigger, 2 = pending (read-only), 3 = enable, 4 = clear (write-only, reads zero) and 5 = output mode, a gate bit of 1 lets its line reach the pending bit and a gate bit of 0 blocks it.
- R3: A trigger bit of 1 sets the pending bit only on a rising edge of the line; a line that stays high does not set it again after a clear.
- R4: A trigger bit of 0 makes the line level-sensitive, so the pending bit is set, and set again after a clear, for as long as the ungated line is high.
- R5: Writing to the clear register clears exactly the pending bits written as 1 and leaves the others unchanged.
- R6: When a clear and a new qualifying event hit the same line in the same cycle, the pending bit stays set.
- R7: In level mode (mode 0), `irq_out` is high exactly while some pending bit has its enable bit set.
- R8: In pulse mode, `irq_out` is high for one cycle each time a new enabled pending bit appears, and is low while the set of enabled pending bits is unchanged.
- R9: The mode register is written as all zeros or all ones; bit 0 selects pulse mode, and a read returns that bit copied into all 32 bits.
- R10: Gate, trigger, pending and enable bits at or above the channel count read as zero and cannot be written.
- R11: A read of the enable register in the cycle after a write returns the value just written, limited to the channel count.
- R12: Reconfiguring a line in the order block, set trigger, set enable, clear, unblock records no event and leaves the output low when the line is already high while it is blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_out | output | 1 | Combined interrupt |

## Verification
The pattern table drives single rising edges, inputs held high across several cycles, lines blocked by their gate bit, and clears that land on the same cycle as a new event. These tell edge capture from level capture and show whether set or clear wins. Pulse mode is driven with a first event and then a second event while the first is still pending, which shows whether a pulse appears for each new bit and lasts one cycle. A line that is already high during the reconfiguration order shows whether unblocking it produces a false edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_GATE = 3'd0,
    SEL_TRIG = 3'd1,
    SEL_PEND = 3'd2,
    SEL_EN   = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_MODE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N-1:0]      gate_q,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      en_q,
  output logic              pulse_mode_q,
  output logic [N-1:0]      clr_vec
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  // Clear strobes last one cycle, only while the write is present.
  assign clr_vec = (wr && sel == SEL_CLR) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q       <= '0;
      trig_q       <= '0;
      en_q         <= '0;
      pulse_mode_q <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_GATE: gate_q       <= wdata[N-1:0];
        SEL_TRIG: trig_q       <= wdata[N-1:0];
        SEL_EN:   en_q         <= wdata[N-1:0];
        SEL_MODE: pulse_mode_q <= wdata[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_capture.sv
module irq_agg_capture #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] gate,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] set_vec
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic line_q;
    logic event_hit;

    // Rising edge when the trigger bit is 1, high level otherwise.
    assign event_hit  = trig[i] ? (lines[i] & ~line_q) : lines[i];
    assign set_vec[i] = gate[i] & event_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q    <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        line_q    <= lines[i];
        // A new event outranks a clear in the same cycle.
        pend_q[i] <= set_vec[i] | (pend_q[i] & ~clr_vec[i]);
      end
    end
  end
endmodule

// File: rtl/irq_agg_outgen.sv
module irq_agg_outgen #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] en,
  input  logic         pulse_mode,
  output logic         irq_out
);
  logic [N-1:0] live;
  logic [N-1:0] live_q;
  logic         fresh;

  assign live  = pend & en;
  assign fresh = |(live & ~live_q);

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live;
  end

  assign irq_out = pulse_mode ? fresh : (|live);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [N-1:0] gate_q, trig_q, en_q, clr_vec, pend_q, set_vec;
  logic         pulse_mode_q;

  irq_agg_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .gate_q(gate_q), .trig_q(trig_q), .en_q(en_q),
    .pulse_mode_q(pulse_mode_q), .clr_vec(clr_vec)
  );

  irq_agg_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .gate(gate_q), .trig(trig_q),
    .clr_vec(clr_vec), .pend_q(pend_q), .set_vec(set_vec)
  );

  irq_agg_outgen #(.N(N)) u_out (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .en(en_q),
    .pulse_mode(pulse_mode_q), .irq_out(irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      SEL_GATE: reg_rdata[N-1:0] = gate_q;
      SEL_TRIG: reg_rdata[N-1:0] = trig_q;
      SEL_PEND: reg_rdata[N-1:0] = pend_q;
      SEL_EN:   reg_rdata[N-1:0] = en_q;
      SEL_MODE: reg_rdata        = {DATA_W{pulse_mode_q}};
      default:  reg_rdata        = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_out,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      en,
  input logic [N-1:0]      gate,
  input logic              pulse_mode,
  input logic [N-1:0]      set_vec
);
  localparam logic [DATA_W-1:0] LOW_BITS = DATA_W'((64'd1 << N) - 64'd1);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && !irq_out));

  p_gate_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(gate)) == '0));

  p_clear_only_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_CLR) |=>
      ((pend & ~$past(set_vec) & $past(reg_wdata[N-1:0])) == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));

  p_level_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && (pend & en) != '0) |-> irq_out);

  p_level_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && (pend & en) == '0) |-> !irq_out);

  p_pulse_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && $stable(pend & en)) |-> !irq_out);

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != SEL_MODE) |-> ((reg_rdata & ~LOW_BITS) == '0));
endmodule

bind irq_aggregator irq_agg_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .pend(pend_q), .en(en_q), .gate(gate_q), .pulse_mode(pulse_mode_q),
  .set_vec(set_vec)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam int STEPS = 10;

  // Config for the table: gate 0x0FF, trigger 0x00F (edge on 0..3), enable 0x00F.
  localparam logic [N-1:0] T_IN  [STEPS] = '{12'h001, 12'h001, 12'h110, 12'h000, 12'h030,
                                             12'h002, 12'h002, 12'h000, 12'h004, 12'h000};
  localparam logic [N-1:0] T_CLR [STEPS] = '{12'h000, 12'h001, 12'h000, 12'h010, 12'h010,
                                             12'h000, 12'h030, 12'h002, 12'h004, 12'h004};
  localparam logic [N-1:0] T_PND [STEPS] = '{12'h001, 12'h000, 12'h010, 12'h000, 12'h030,
                                             12'h032, 12'h002, 12'h000, 12'h004, 12'h000};
  localparam logic         T_OUT [STEPS] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                             1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int checks = 0;
  int failures = 0;

  irq_aggregator #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(3'd2, v); check("R1 pending", v, 32'h0);
    rd(3'd3, v); check("R1 enable", v, 32'h0);
    rd(3'd5, v); check("R1 mode", v, 32'h0);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R10 / R11: enable readback limited to channel count
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R10 R11 enable readback", v, 32'h0000_0FFF);

    wr(3'd0, 32'h0000_00FF);
    wr(3'd1, 32'h0000_000F);
    wr(3'd3, 32'h0000_000F);
    rd(3'd4, v); check("R5 clear reads zero", v, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int s = 0; s < STEPS; s++) begin
      @(negedge clk);
      irq_in = T_IN[s];
      reg_wr = (T_CLR[s] != '0);
      reg_addr = 3'd4;
      reg_wdata = 32'(T_CLR[s]);
      @(negedge clk);
      reg_wr = 1'b0;
      rd(3'd2, v); check($sformatf("R2-R6 step %0d pending", s), v, 32'(T_PND[s]));
      check($sformatf("R7 step %0d irq_out", s), {31'b0, irq_out}, {31'b0, T_OUT[s]});
    end

    // R12: reconfigure channel 6 while its line is high
    wr(3'd0, 32'h0000_00BF);
    @(negedge clk); irq_in = 12'h040;
    wr(3'd1, 32'h0000_004F);
    wr(3'd3, 32'h0000_004F);
    wr(3'd4, 32'h0000_0040);
    wr(3'd0, 32'h0000_00FF);
    rd(3'd2, v); check("R12 no false event", v, 32'h0);
    check("R12 irq_out low", {31'b0, irq_out}, 32'h0);
    @(negedge clk); rd(3'd2, v); check("R12 still clear", v, 32'h0);
    irq_in = 12'h000;
    @(negedge clk); irq_in = 12'h040;
    @(negedge clk); rd(3'd2, v); check("R12 R3 later edge captured", v, 32'h40);
    check("R12 irq_out after edge", {31'b0, irq_out}, 32'h1);
    irq_in = '0;
    wr(3'd4, 32'h0000_0FFF);

    // R8 / R9: pulse mode
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R9 mode readback", v, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_000F);
    check("R8 idle low", {31'b0, irq_out}, 32'h0);
    irq_in = 12'h001;
    @(negedge clk); check("R8 first pulse", {31'b0, irq_out}, 32'h1);
    @(negedge clk); check("R8 pulse one cycle", {31'b0, irq_out}, 32'h0);
    irq_in = 12'h003;
    @(negedge clk); check("R8 second new bit pulses", {31'b0, irq_out}, 32'h1);
    @(negedge clk); check("R8 second pulse ends", {31'b0, irq_out}, 32'h0);
    rd(3'd2, v); check("R3 held lines no recapture", v, 32'h3);

    // R4: level line re-sets after clear while high
    wr(3'd5, 32'h0);
    irq_in = 12'h080;
    @(negedge clk);
    wr(3'd4, 32'h0000_0080);
    rd(3'd2, v); check("R4 level re-set", v & 32'h80, 32'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule